// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block produces a serial bit clock for external modulators by dividing the system clock by a programmable ratio. An 8-bit setting selects the ratio as setting plus one, so the span runs from 2 to 256. A setting of zero keeps the output silent. A global interface enable gates generation. While the enable is high, the setting is frozen. The setting input is copied into a locked register only during cycles in which the enable is low.

Besides the clock, the block drives a one-cycle terminal-count pulse once per output period. It also exposes the locked setting, so that a neighbouring clock-absence checker can use the same value as its timeout threshold. The output clock comes straight from a flop. It starts low after enable, and it parks low on the first edge at which the enable is seen low.

Top module: `sclk_divider_gen`

## Requirements
- R1: During and right after reset, the clock output, the terminal-count pulse and the locked setting are all 0.
- R2: With a locked setting of 0, the clock output and the terminal-count pulse stay 0 even while enabled.
- R3: With a locked setting N in 1..255, the output period is exactly N+1 system clock cycles.
- R4: In each period the output is low for ceil((N+1)/2) cycles and then high for floor((N+1)/2) cycles, which gives a 50% duty cycle for even ratios.
- R5: Counting the first clock edge that samples the enable high as edge 1, the output is low after edges 1 to ceil((N+1)/2) and goes high after the next edge.
- R6: The setting input is captured into the locked setting only on edges where the enable is sampled low. Changes made while enabled change neither the ratio nor the exposed locked setting.
- R7: After any clock edge that samples the enable low, the clock output and the terminal-count pulse are 0.
- R8: The terminal-count pulse is high for exactly one cycle per period, during the last high cycle of the output, so the output falls on the following cycle.
- R9: A setting that is presented in the same cycle in which the enable rises is not captured. The previously locked value governs the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global interface enable |
| div_set_i | input | 8 | Requested divider setting (ratio = setting + 1, 0 = off) |
| sclk_o | output | 1 | Divided serial clock, driven from a flop |
| tc_o | output | 1 | Terminal-count pulse, one cycle per output period |
| div_lock_o | output | 8 | Locked setting, usable as the absence-detection threshold |

## Verification
Two pairs of events can meet in one cycle. The first is a falling enable on the very edge where the terminal count and the last high cycle would have been produced. The second is a setting change that arrives on the same edge at which the enable rises. The bench provokes the first by dropping the enable just before the wrap edge of a ratio-6 run, and it expects both outputs to be low after that edge. It provokes the second by raising the enable and presenting a new setting on the same half-cycle, and it expects the old ratio in the waveform and the old value on the locked-setting port.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   // Widest divider setting the helpers below accept.
   localparam int unsigned MAX_DIV_W = 16;

   // Cycles the output spends low in one period: ratio - floor(ratio/2).
   function automatic logic [MAX_DIV_W:0] low_phase_len(input logic [MAX_DIV_W-1:0] div);
      logic [MAX_DIV_W:0] ratio;
      ratio = {1'b0, div} + {{MAX_DIV_W{1'b0}}, 1'b1};
      return ratio - (ratio >> 1);
   endfunction

   // Output phase decoded from the counter (used for readability in the stage).
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } sclk_phase_e;

endpackage

// File: rtl/sclk_cfg_lock.sv
module sclk_cfg_lock #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_set_i,
   output logic [DIV_W-1:0] div_q_o
);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         div_q_o <= '0;
      end else if (!en_i) begin
         div_q_o <= div_set_i;
      end
   end

   // R6: while enabled the locked setting never moves
   p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $past(en_i) |-> $stable(div_q_o));

endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_q_i,
   output logic [DIV_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [DIV_W-1:0] cnt_nxt;

   always_comb begin
      wrap_o = (cnt_o == div_q_i);
      if (!run_i || wrap_o) begin
         cnt_nxt = '0;
      end else begin
         cnt_nxt = cnt_o + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_o <= '0;
      end else begin
         cnt_o <= cnt_nxt;
      end
   end

   // R3: counter stays inside 0..setting so the period is setting+1
   p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_o <= div_q_i);

   // R5: an idle counter restarts from zero
   p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !$past(run_i) |-> (cnt_o == '0));

endmodule

// File: rtl/sclk_out_stage.sv
module sclk_out_stage #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] cnt_i,
   input  logic [DIV_W-1:0] div_q_i,
   input  logic             wrap_i,
   output logic             sclk_o,
   output logic             tc_o
);

   import sclk_div_pkg::*;

   localparam int unsigned EXT_W = DIV_W + 1;

   logic [EXT_W-1:0] low_len;
   sclk_phase_e      phase_nxt;
   logic             tc_nxt;

   always_comb begin
      low_len = EXT_W'(low_phase_len(MAX_DIV_W'(div_q_i)));
      if (run_i && ({1'b0, cnt_i} >= low_len)) begin
         phase_nxt = PH_HIGH;
      end else begin
         phase_nxt = PH_LOW;
      end
      tc_nxt = run_i && wrap_i;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         sclk_o <= 1'b0;
         tc_o   <= 1'b0;
      end else begin
         sclk_o <= (phase_nxt == PH_HIGH);
         tc_o   <= tc_nxt;
      end
   end

   // R8: pulse only in a high cycle, and the output falls right after it
   p_tc_in_high_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tc_o |-> sclk_o);
   p_tc_then_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tc_o |=> !sclk_o);

endmodule

// File: rtl/sclk_divider_gen.sv
module sclk_divider_gen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_set_i,
   output logic             sclk_o,
   output logic             tc_o,
   output logic [DIV_W-1:0] div_lock_o
);

   initial begin
      a_div_w_range: assert (DIV_W >= 2 && DIV_W <= sclk_div_pkg::MAX_DIV_W)
         else $error("sclk_divider_gen: DIV_W out of range");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt;
   logic             wrap;
   logic             run;

   sclk_cfg_lock #(.DIV_W(DIV_W)) u_lock (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .en_i      (en_i),
      .div_set_i (div_set_i),
      .div_q_o   (div_q)
   );

   assign run = en_i && (div_q != '0);

   sclk_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .run_i   (run),
      .div_q_i (div_q),
      .cnt_o   (cnt),
      .wrap_o  (wrap)
   );

   sclk_out_stage #(.DIV_W(DIV_W)) u_out (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .run_i   (run),
      .cnt_i   (cnt),
      .div_q_i (div_q),
      .wrap_i  (wrap),
      .sclk_o  (sclk_o),
      .tc_o    (tc_o)
   );

   assign div_lock_o = div_q;

   // R7: parked low after an edge that saw the enable low
   p_park_low_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !$past(en_i) |-> (!sclk_o && !tc_o));

   // R2: a zero setting keeps both outputs quiet
   p_zero_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $past(div_q == '0) |-> (!sclk_o && !tc_o));

endmodule

// File: tb/sim_sclk_divider_gen.sv
`timescale 1ns/1ps
module sim_sclk_divider_gen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en;
   logic [7:0] div_set;
   logic       sclk;
   logic       tc;
   logic [7:0] div_lock;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   sclk_divider_gen #(.DIV_W(8)) u0 (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .en_i       (en),
      .div_set_i  (div_set),
      .sclk_o     (sclk),
      .tc_o       (tc),
      .div_lock_o (div_lock)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs ncyc edges after the enable was raised on the preceding negedge.
   // Compares against a ratio of exp_d+1; optionally changes div_set on edge chg_k.
   task automatic run_seq(input int exp_d, input int ncyc, input string req,
                          input int chg_k, input int chg_val);
      int r   = exp_d + 1;
      int lo  = r - r / 2;
      int bad_o = 0;
      int bad_t = 0;
      int a_o = 0, e_o = 0, a_t = 0, e_t = 0;
      for (int k = 1; k <= ncyc; k++) begin
         @(negedge clk);
         if (k == chg_k) div_set = chg_val[7:0];
         begin
            int ph = (k - 1) % r;
            int xo = (exp_d != 0 && ph >= lo) ? 1 : 0;
            int xt = (exp_d != 0 && ph == r - 1) ? 1 : 0;
            if (int'(sclk) != xo && bad_o == 0) begin a_o = sclk; e_o = xo; end
            if (int'(tc) != xt && bad_t == 0) begin a_t = tc; e_t = xt; end
            if (int'(sclk) != xo) bad_o++;
            if (int'(tc) != xt) bad_t++;
         end
      end
      check(bad_o == 0, {req, " clock waveform"}, a_o, e_o);
      check(bad_t == 0, {req, " terminal count"}, a_t, e_t);
   endtask

   task automatic prep(input int d);
      @(negedge clk);
      en = 1'b0;
      div_set = d[7:0];
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en = 1'b0; div_set = 8'hA5;
      repeat (3) @(negedge clk);
      check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
      check(tc == 1'b0, "R1 tc in reset", tc, 0);
      check(div_lock == 8'd0, "R1 lock in reset", div_lock, 0);
      div_set = 8'd0;
      rst_n = 1'b1;
      @(negedge clk);
      check(sclk == 1'b0 && tc == 1'b0, "R1 outputs after reset", {sclk, tc}, 0);
   endtask

   // R2 zero setting, R3/R4/R5 ratios, R7 park after disable
   task automatic t_ratio(input int d, input int periods);
      prep(d);
      check(div_lock == d[7:0], "R6 captured while disabled", div_lock, d);
      en = 1'b1;
      run_seq(d, periods * (d + 1) + 2, (d == 0) ? "R2" : "R3 R4 R5", 0, 0);
      en = 1'b0;
      @(negedge clk);
      check(sclk == 1'b0 && tc == 1'b0, "R7 parked after disable", {sclk, tc}, 0);
   endtask

   // R6: changes while enabled are ignored, taken once disabled
   task automatic t_lock();
      prep(4);
      en = 1'b1;
      run_seq(4, 17, "R6 ratio under change", 3, 9);
      check(div_lock == 8'd4, "R6 lock held while enabled", div_lock, 4);
      en = 1'b0;
      @(negedge clk);
      check(div_lock == 8'd9, "R6 taken after disable", div_lock, 9);
   endtask

   // R9: setting presented in the enable-rise cycle is not taken
   task automatic t_same_cycle();
      prep(3);
      en = 1'b1;
      div_set = 8'd7;
      run_seq(3, 10, "R9 ratio", 0, 0);
      check(div_lock == 8'd3, "R9 old value locked", div_lock, 3);
      en = 1'b0;
      @(negedge clk);
   endtask

   // R7/R8: disable lands on the terminal-count edge
   task automatic t_disable_at_tc();
      prep(5);
      en = 1'b1;
      run_seq(5, 5, "R8 before wrap", 0, 0);
      en = 1'b0;
      @(negedge clk);
      check(sclk == 1'b0, "R7 sclk on wrap-edge disable", sclk, 0);
      check(tc == 1'b0, "R7 tc on wrap-edge disable", tc, 0);
   endtask

   initial begin
      t_reset();
      t_ratio(0, 3);
      t_ratio(1, 4);
      t_ratio(2, 4);
      t_ratio(3, 3);
      t_ratio(6, 3);
      t_ratio(255, 2);
      t_lock();
      t_same_cycle();
      t_disable_at_tc();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule